// File: doc/BRIEF.md
# Snooping MSI Coherence Controller for a Writeback Cache

This block is the coherence engine of one private, direct-mapped, writeback data cache on an atomic shared bus. Each line holds one of three states: Invalid, Shared (clean, possibly held elsewhere) or Modified (dirty, held only here). The processor side issues single-word reads and writes. A miss or an upgrade becomes one of three bus commands: a plain read, a read-for-ownership that invalidates other copies, or a writeback of a dirty victim.

Every instance watches all commands it did not issue itself. When another requester reads or claims a line that this cache holds Modified, the controller drives the line's data onto the bus in the same cycle. It also raises an inhibit flag so that the memory does not answer. Both the memory and the requester take that flushed word.

Several instances share one bus through the round-robin arbiter in this project. Each bus command occupies exactly one granted cycle.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: A processor read that misses (tag absent or line Invalid) issues exactly one bus read (command code 1) carrying the word address. It returns the word seen on `bus_rdata` in that cycle and leaves the line Shared.
- R2: A processor write to a line that is not Modified, whether absent or Shared, issues exactly one read-for-ownership (code 2). The line then holds the written word in state Modified, and a later read returns that word.
- R3: Reads and writes to a Modified line, and reads to a Shared line, complete without any bus command.
- R4: A snooped bus read from another cache that hits a Modified line raises `snp_inhibit` and drives the line's word on `snp_data` in the same cycle. The line becomes Shared, so a later local write needs a read-for-ownership.
- R5: A snooped read-for-ownership that hits a Modified line flushes in the same way, and the line becomes Invalid, so a later local read misses.
- R6: A snooped read-for-ownership that hits a Shared line invalidates it without raising the inhibit. A snooped bus read that hits a Shared line changes nothing.
- R7: A miss whose set holds a Modified line with another tag first issues a writeback (code 3) with the victim's address and word. Only after that does it issue the refill read or read-for-ownership. The written-back word is then available from memory.
- R8: A miss whose victim is Shared or Invalid issues no writeback.
- R9: After cache A reads, cache C reads, C writes and A reads one address, both A and C hold the line Shared. A's last read receives C's word, and memory keeps that word for a third reader.
- R10: After reset every line is Invalid, `bus_req` and `cpu_rdy` are low, and the first access to any address misses.
- R11: A cache drives a non-idle bus command only in a cycle where it holds the grant, and each command lasts one cycle. The arbiter grants at most one requester per cycle and serves concurrent requesters round-robin, so every one of them completes.
- R12: `snp_inhibit` rises only for another cache's read or read-for-ownership that hits a Modified line. A cache never reacts to its own command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpu_req | input | 1 | Processor access pending; held until `cpu_rdy` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address; the low bits select the set |
| cpu_wdata | input | DATA_W | Write word |
| cpu_rdy | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | DATA_W | Read word, valid with `cpu_rdy` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Grant from the arbiter, same cycle |
| bus_cmd | output | 2 | 0 idle, 1 read, 2 read-for-ownership, 3 writeback; driven only while granted |
| bus_addr | output | ADDR_W | Address of the driven command |
| bus_wdata | output | DATA_W | Writeback word |
| snp_cmd | input | 2 | Command currently on the shared bus |
| snp_addr | input | ADDR_W | Address currently on the shared bus |
| bus_rdata | input | DATA_W | Word returned to the requester (a flush or memory) |
| snp_inhibit | output | 1 | This cache supplies the data; memory must stay silent |
| snp_data | output | DATA_W | Flushed word, zero when not inhibiting |

## Verification
On every cycle the assertions check the bus handshake: commands appear only under grant, the inhibit appears only for a foreign read or read-for-ownership, and completions are single-cycle pulses that follow a request. They also check ordering, so that a writeback is always followed by a refill request and a fill is always followed by completion. The scenarios alone show the state transitions and the data they move. That includes which cache supplies a word, that a Shared copy vanishes after another cache claims ownership, that the victim reaches memory before the refill, and that the four-step shared sequence ends with both caches Shared. The bench observes all of this through the bus traffic and the returned words.

// File: rtl/msi_pkg.sv
package msi_pkg;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_READ  = 2'd1,
        CMD_OWN   = 2'd2,
        CMD_WBACK = 2'd3
    } bus_cmd_e;

    typedef enum logic [1:0] {
        LINE_INV = 2'd0,
        LINE_SHR = 2'd1,
        LINE_MOD = 2'd2
    } line_st_e;

    typedef enum logic [1:0] {
        CTL_IDLE  = 2'd0,
        CTL_EVICT = 2'd1,
        CTL_FILL  = 2'd2,
        CTL_RESP  = 2'd3
    } ctl_st_e;

endpackage

// File: rtl/msi_line_store.sv
// Direct-mapped line arrays: coherence state, tag and one data word per set.
// Port a serves the processor side, port b serves the snooper.
module msi_line_store
    import msi_pkg::*;
#(
    parameter int SETS   = 4,
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32,
    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  a_idx,
    output logic [1:0]        a_state,
    output logic [TAG_W-1:0]  a_tag,
    output logic [DATA_W-1:0] a_data,
    input  logic [IDX_W-1:0]  b_idx,
    output logic [1:0]        b_state,
    output logic [TAG_W-1:0]  b_tag,
    output logic [DATA_W-1:0] b_data,
    input  logic              s_we,
    input  logic [IDX_W-1:0]  s_idx,
    input  logic [1:0]        s_state,
    input  logic              c_we,
    input  logic [IDX_W-1:0]  c_idx,
    input  logic [TAG_W-1:0]  c_tag,
    input  logic [DATA_W-1:0] c_data,
    input  logic [1:0]        c_state
);

    logic [SETS-1:0][1:0]        st_q,   st_d;
    logic [SETS-1:0][TAG_W-1:0]  tag_q,  tag_d;
    logic [SETS-1:0][DATA_W-1:0] data_q, data_d;

    assign a_state = st_q[a_idx];
    assign a_tag   = tag_q[a_idx];
    assign a_data  = data_q[a_idx];
    assign b_state = st_q[b_idx];
    assign b_tag   = tag_q[b_idx];
    assign b_data  = data_q[b_idx];

    // The controller write wins; the controller never writes a set that a live snoop targets.
    always_comb begin
        st_d   = st_q;
        tag_d  = tag_q;
        data_d = data_q;
        for (int s = 0; s < SETS; s++) begin
            if (c_we && c_idx == IDX_W'(s)) begin
                st_d[s]   = c_state;
                tag_d[s]  = c_tag;
                data_d[s] = c_data;
            end else if (s_we && s_idx == IDX_W'(s)) begin
                st_d[s] = s_state;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q   <= '0;
            tag_q  <= '0;
            data_q <= '0;
        end else begin
            st_q   <= st_d;
            tag_q  <= tag_d;
            data_q <= data_d;
        end
    end

endmodule

// File: rtl/msi_snoop_unit.sv
// Reaction to a command seen on the bus: state downgrade and flush decision.
module msi_snoop_unit
    import msi_pkg::*;
#(
    parameter int TAG_W  = 6,
    parameter int DATA_W = 32
) (
    input  logic [1:0]        snp_cmd,
    input  logic              snp_live,
    input  logic [1:0]        line_state,
    input  logic [TAG_W-1:0]  line_tag,
    input  logic [TAG_W-1:0]  snp_tag,
    input  logic [DATA_W-1:0] line_data,
    output logic              upd_en,
    output logic [1:0]        upd_state,
    output logic              inhibit,
    output logic [DATA_W-1:0] flush_data
);

    logic hit;

    always_comb begin
        hit       = snp_live && (line_state != LINE_INV) && (line_tag == snp_tag);
        upd_en    = 1'b0;
        upd_state = line_state;
        inhibit   = 1'b0;
        if (hit) begin
            case (bus_cmd_e'(snp_cmd))
                CMD_READ: begin
                    if (line_state == LINE_MOD) begin
                        inhibit   = 1'b1;
                        upd_en    = 1'b1;
                        upd_state = LINE_SHR;
                    end
                end
                CMD_OWN: begin
                    inhibit   = (line_state == LINE_MOD);
                    upd_en    = 1'b1;
                    upd_state = LINE_INV;
                end
                default: ;
            endcase
        end
        flush_data = inhibit ? line_data : '0;
    end

endmodule

// File: rtl/msi_bus_arbiter.sv
// Round-robin grant for the shared bus; the grant is combinational from the requests.
module msi_bus_arbiter #(
    parameter int N   = 3,
    localparam int PW = (N > 1) ? $clog2(N) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt
);

    logic [PW-1:0] ptr_q, ptr_d;

    always_comb begin
        int   j;
        logic found;
        gnt   = '0;
        ptr_d = ptr_q;
        found = 1'b0;
        j     = 0;
        for (int k = 0; k < N; k++) begin
            j = int'(ptr_q) + k;
            if (j >= N) j = j - N;
            if (!found && req[j]) begin
                gnt[j] = 1'b1;
                found  = 1'b1;
                ptr_d  = (j == N - 1) ? '0 : PW'(j + 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

endmodule

// File: rtl/msi_snoop_ctrl.sv
// Per-cache MSI controller: processor sequencing, bus mastering and snoop response.
module msi_snoop_ctrl
    import msi_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 32,
    parameter int SETS   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_rdy,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    input  logic              bus_gnt,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic              snp_inhibit,
    output logic [DATA_W-1:0] snp_data
);

    localparam int IDX_W = (SETS > 1) ? $clog2(SETS) : 1;
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        ctl_st_e           st;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic [IDX_W-1:0]  cpu_idx, snp_idx;
    logic [TAG_W-1:0]  cpu_tag, snp_tag;
    logic [1:0]        a_state, b_state;
    logic [TAG_W-1:0]  a_tag, b_tag;
    logic [DATA_W-1:0] a_data, b_data;
    logic              s_we;
    logic [1:0]        s_state;
    logic              c_we;
    logic [TAG_W-1:0]  c_tag;
    logic [DATA_W-1:0] c_data;
    logic [1:0]        c_state;
    logic              snp_live, tag_hit, clash;
    logic              req_c;
    bus_cmd_e          cmd_c;
    logic [ADDR_W-1:0] addr_c;
    logic [DATA_W-1:0] wdata_c;

    assign cpu_idx  = cpu_addr[IDX_W-1:0];
    assign cpu_tag  = cpu_addr[ADDR_W-1:IDX_W];
    assign snp_idx  = snp_addr[IDX_W-1:0];
    assign snp_tag  = snp_addr[ADDR_W-1:IDX_W];
    // A cache's own command, visible on the shared lines, is never snooped.
    assign snp_live = (snp_cmd != CMD_NONE) && !bus_gnt;
    assign tag_hit  = (a_state != LINE_INV) && (a_tag == cpu_tag);
    assign clash    = snp_live && (snp_idx == cpu_idx);

    msi_line_store #(
        .SETS   (SETS),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .a_idx   (cpu_idx),
        .a_state (a_state),
        .a_tag   (a_tag),
        .a_data  (a_data),
        .b_idx   (snp_idx),
        .b_state (b_state),
        .b_tag   (b_tag),
        .b_data  (b_data),
        .s_we    (s_we),
        .s_idx   (snp_idx),
        .s_state (s_state),
        .c_we    (c_we),
        .c_idx   (cpu_idx),
        .c_tag   (c_tag),
        .c_data  (c_data),
        .c_state (c_state)
    );

    msi_snoop_unit #(
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_snoop (
        .snp_cmd    (snp_cmd),
        .snp_live   (snp_live),
        .line_state (b_state),
        .line_tag   (b_tag),
        .snp_tag    (snp_tag),
        .line_data  (b_data),
        .upd_en     (s_we),
        .upd_state  (s_state),
        .inhibit    (snp_inhibit),
        .flush_data (snp_data)
    );

    always_comb begin
        r_d     = r_q;
        c_we    = 1'b0;
        c_tag   = cpu_tag;
        c_data  = a_data;
        c_state = a_state;
        req_c   = 1'b0;
        cmd_c   = CMD_NONE;
        addr_c  = cpu_addr;
        wdata_c = '0;
        case (r_q.st)
            CTL_IDLE: begin
                // Hold off for one cycle while a foreign command touches this set.
                if (cpu_req && !clash) begin
                    if (!cpu_we && tag_hit) begin
                        r_d.rdata = a_data;
                        r_d.st    = CTL_RESP;
                    end else if (cpu_we && tag_hit && a_state == LINE_MOD) begin
                        c_we    = 1'b1;
                        c_data  = cpu_wdata;
                        c_state = LINE_MOD;
                        r_d.st  = CTL_RESP;
                    end else if (a_state == LINE_MOD) begin
                        r_d.st = CTL_EVICT;
                    end else begin
                        r_d.st = CTL_FILL;
                    end
                end
            end
            CTL_EVICT: begin
                // A snoop may have cleaned or removed the victim while waiting.
                if (a_state == LINE_MOD) begin
                    req_c   = 1'b1;
                    cmd_c   = CMD_WBACK;
                    addr_c  = {a_tag, cpu_idx};
                    wdata_c = a_data;
                    if (bus_gnt) begin
                        c_we    = 1'b1;
                        c_tag   = a_tag;
                        c_state = LINE_SHR;
                        r_d.st  = CTL_FILL;
                    end
                end else begin
                    r_d.st = CTL_FILL;
                end
            end
            CTL_FILL: begin
                req_c = 1'b1;
                cmd_c = cpu_we ? CMD_OWN : CMD_READ;
                if (bus_gnt) begin
                    c_we      = 1'b1;
                    c_data    = cpu_we ? cpu_wdata : bus_rdata;
                    c_state   = cpu_we ? LINE_MOD : LINE_SHR;
                    r_d.rdata = bus_rdata;
                    r_d.st    = CTL_RESP;
                end
            end
            default: begin
                r_d.st = CTL_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st    <= CTL_IDLE;
            r_q.rdata <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign bus_req   = req_c;
    assign bus_cmd   = bus_gnt ? cmd_c   : CMD_NONE;
    assign bus_addr  = bus_gnt ? addr_c  : '0;
    assign bus_wdata = bus_gnt ? wdata_c : '0;
    assign cpu_rdy   = (r_q.st == CTL_RESP);
    assign cpu_rdata = r_q.rdata;

endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk
    import msi_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       cpu_req,
    input logic       cpu_rdy,
    input logic       bus_req,
    input logic       bus_gnt,
    input logic [1:0] bus_cmd,
    input logic [1:0] snp_cmd,
    input logic       snp_inhibit
);

    assert_cmd_under_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_NONE) |-> bus_gnt);

    assert_inhibit_foreign_R12: assert property (@(posedge clk) disable iff (!rst_n)
        snp_inhibit |-> ((snp_cmd == CMD_READ || snp_cmd == CMD_OWN) && !bus_gnt));

    assert_rdy_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |=> !cpu_rdy);

    assert_rdy_after_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rdy |-> $past(cpu_req));

    assert_wback_then_refill_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_WBACK) |=> bus_req);

    assert_wback_needs_access_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_WBACK) |-> cpu_req);

    assert_fill_completes_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_READ || bus_cmd == CMD_OWN) |=> cpu_rdy);

endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk u_chk (.*);

// File: tb/msi_snoop_ctrl_bench.sv
`timescale 1ns/1ps
module msi_snoop_ctrl_bench;
    import msi_pkg::*;

    localparam int N  = 3;
    localparam int AW = 8;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          cpu_req   [N];
    logic          cpu_we    [N];
    logic [AW-1:0] cpu_addr  [N];
    logic [DW-1:0] cpu_wdata [N];
    logic          cpu_rdy   [N];
    logic [DW-1:0] cpu_rdata [N];
    logic [N-1:0]  bus_req, bus_gnt, snp_inhibit;
    logic [1:0]    bus_cmd   [N];
    logic [AW-1:0] bus_addr  [N];
    logic [DW-1:0] bus_wdata [N];
    logic [DW-1:0] snp_data  [N];

    logic [1:0]    sh_cmd;
    logic [AW-1:0] sh_addr;
    logic [DW-1:0] sh_wdata, flush_or, bus_rdata;
    int            sh_master;
    logic [DW-1:0] mem [256];

    function automatic logic [DW-1:0] init_word(logic [AW-1:0] a);
        return 32'hC0DE0000 | DW'(a);
    endfunction

    always_comb begin
        sh_cmd = 2'd0; sh_addr = '0; sh_wdata = '0; sh_master = 0; flush_or = '0;
        for (int i = 0; i < N; i++) begin
            if (bus_gnt[i]) begin
                sh_cmd = bus_cmd[i]; sh_addr = bus_addr[i];
                sh_wdata = bus_wdata[i]; sh_master = i;
            end
            flush_or = flush_or | snp_data[i];
        end
        bus_rdata = (|snp_inhibit) ? flush_or : mem[sh_addr];
    end

    // Memory model: takes writebacks and flushed words.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int a = 0; a < 256; a++) mem[a] <= init_word(AW'(a));
        end else if (sh_cmd == CMD_WBACK) begin
            mem[sh_addr] <= sh_wdata;
        end else if (|snp_inhibit) begin
            mem[sh_addr] <= flush_or;
        end
    end

    msi_bus_arbiter #(.N(N)) u_arb (.clk(clk), .rst_n(rst_n), .req(bus_req), .gnt(bus_gnt));

    for (genvar i = 0; i < N; i++) begin : g_cache
        msi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETS(4)) u_msi_snoop_ctrl (
            .clk(clk), .rst_n(rst_n),
            .cpu_req(cpu_req[i]), .cpu_we(cpu_we[i]), .cpu_addr(cpu_addr[i]),
            .cpu_wdata(cpu_wdata[i]), .cpu_rdy(cpu_rdy[i]), .cpu_rdata(cpu_rdata[i]),
            .bus_req(bus_req[i]), .bus_gnt(bus_gnt[i]), .bus_cmd(bus_cmd[i]),
            .bus_addr(bus_addr[i]), .bus_wdata(bus_wdata[i]),
            .snp_cmd(sh_cmd), .snp_addr(sh_addr), .bus_rdata(bus_rdata),
            .snp_inhibit(snp_inhibit[i]), .snp_data(snp_data[i]));
    end

    int nchk = 0;
    int nfail = 0;
    bit done = 1'b0;

    function automatic void chk(bit ok, string req, string what, logic [DW-1:0] act, logic [DW-1:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endfunction

    typedef struct {
        logic [1:0]    cmd;
        int            master;
        logic [AW-1:0] addr;
        logic          inh;
        logic [DW-1:0] data;
        string         req;
    } item_t;

    item_t expq[$];
    bit            free_mode = 1'b0;
    logic [AW-1:0] free_addr [N];
    int            free_seen = 0;

    task automatic push(logic [1:0] cmd, int m, logic [AW-1:0] a, logic inh, logic [DW-1:0] d, string req);
        item_t it;
        it.cmd = cmd; it.master = m; it.addr = a; it.inh = inh; it.data = d; it.req = req;
        expq.push_back(it);
    endtask

    // Monitor: pops the expected bus traffic and compares each transaction.
    always @(negedge clk) begin
        if (rst_n && sh_cmd != 2'd0) begin
            logic [DW-1:0] d;
            logic [DW-1:0] act_h, exp_h;
            item_t it;
            d = (sh_cmd == CMD_WBACK) ? sh_wdata : bus_rdata;
            chk($onehot(bus_gnt), "R11", "grant not one-hot", DW'(bus_gnt), 32'h1);
            act_h = {20'd0, sh_cmd, 1'b0, snp_inhibit != 0, sh_master[3:0], sh_addr};
            if (free_mode) begin
                exp_h = {20'd0, CMD_READ, 1'b0, 1'b0, sh_master[3:0], free_addr[sh_master]};
                chk(act_h == exp_h, "R11", "concurrent transaction", act_h, exp_h);
                chk(d == init_word(free_addr[sh_master]), "R11", "concurrent data", d, init_word(free_addr[sh_master]));
                free_seen++;
            end else if (expq.size() == 0) begin
                chk(1'b0, "R3", "unexpected bus transaction", act_h, 32'h0);
            end else begin
                it = expq.pop_front();
                exp_h = {20'd0, it.cmd, 1'b0, it.inh, it.master[3:0], it.addr};
                chk(act_h == exp_h, it.req, "bus transaction {cmd,inh,master,addr}", act_h, exp_h);
                chk(d == it.data, it.req, "bus data", d, it.data);
            end
        end
    end

    task automatic op(int p, bit we, logic [AW-1:0] a, logic [DW-1:0] v, string req);
        @(negedge clk);
        cpu_req[p] = 1'b1; cpu_we[p] = we; cpu_addr[p] = a; cpu_wdata[p] = v;
        do @(negedge clk); while (!cpu_rdy[p]);
        if (!we) chk(cpu_rdata[p] == v, req, "read data", cpu_rdata[p], v);
        cpu_req[p] = 1'b0;
        if (!free_mode) chk(expq.size() == 0, req, "expected transactions still pending", DW'(expq.size()), 32'h0);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", nchk - nfail, nchk);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL R11 watchdog expired actual=hung expected=complete");
            summary();
        end
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            cpu_req[i] = 1'b0; cpu_we[i] = 1'b0; cpu_addr[i] = '0; cpu_wdata[i] = '0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: quiet after reset
        chk(bus_req == 0, "R10", "bus_req after reset", DW'(bus_req), 32'h0);
        chk(!cpu_rdy[0] && !cpu_rdy[1] && !cpu_rdy[2], "R10", "cpu_rdy after reset", 32'(cpu_rdy[0]), 32'h0);

        // R1 / R10: cold miss, then hit
        push(CMD_READ, 0, 8'h10, 1'b0, init_word(8'h10), "R1");
        op(0, 1'b0, 8'h10, init_word(8'h10), "R1");
        op(0, 1'b0, 8'h10, init_word(8'h10), "R3");
        // R6: snooped read on Shared does nothing
        push(CMD_READ, 2, 8'h10, 1'b0, init_word(8'h10), "R6");
        op(2, 1'b0, 8'h10, init_word(8'h10), "R1");
        op(0, 1'b0, 8'h10, init_word(8'h10), "R6");
        // R2: upgrade from Shared, then Modified hits
        push(CMD_OWN, 2, 8'h10, 1'b0, init_word(8'h10), "R2");
        op(2, 1'b1, 8'h10, 32'h11111111, "R2");
        op(2, 1'b1, 8'h10, 32'h22222222, "R3");
        op(2, 1'b0, 8'h10, 32'h22222222, "R2");
        // R4 / R9: owner flushes on read, both end Shared
        push(CMD_READ, 0, 8'h10, 1'b1, 32'h22222222, "R4");
        op(0, 1'b0, 8'h10, 32'h22222222, "R9");
        op(0, 1'b0, 8'h10, 32'h22222222, "R9");
        op(2, 1'b0, 8'h10, 32'h22222222, "R9");
        push(CMD_READ, 1, 8'h10, 1'b0, 32'h22222222, "R12");
        op(1, 1'b0, 8'h10, 32'h22222222, "R9");
        // R4: former owner is Shared, so its write needs ownership
        push(CMD_OWN, 2, 8'h10, 1'b0, 32'h22222222, "R4");
        op(2, 1'b1, 8'h10, 32'h33333333, "R4");
        // R5: ownership request flushes and invalidates the owner
        push(CMD_OWN, 1, 8'h10, 1'b1, 32'h33333333, "R5");
        op(1, 1'b1, 8'h10, 32'h44444444, "R5");
        push(CMD_READ, 2, 8'h10, 1'b1, 32'h44444444, "R5");
        op(2, 1'b0, 8'h10, 32'h44444444, "R5");
        op(1, 1'b0, 8'h10, 32'h44444444, "R4");
        // R6: ownership request invalidates a Shared copy silently
        push(CMD_OWN, 1, 8'h10, 1'b0, 32'h44444444, "R6");
        op(1, 1'b1, 8'h10, 32'h55555555, "R6");
        // R7: dirty victim written back before the refill
        push(CMD_WBACK, 1, 8'h10, 1'b0, 32'h55555555, "R7");
        push(CMD_READ, 1, 8'h14, 1'b0, init_word(8'h14), "R7");
        op(1, 1'b0, 8'h14, init_word(8'h14), "R7");
        push(CMD_READ, 0, 8'h10, 1'b0, 32'h55555555, "R7");
        op(0, 1'b0, 8'h10, 32'h55555555, "R7");
        // R8: clean victim, no writeback
        push(CMD_READ, 0, 8'h20, 1'b0, init_word(8'h20), "R8");
        op(0, 1'b0, 8'h20, init_word(8'h20), "R8");
        // R7 on a write miss
        push(CMD_OWN, 0, 8'h20, 1'b0, init_word(8'h20), "R2");
        op(0, 1'b1, 8'h20, 32'h66666666, "R2");
        push(CMD_WBACK, 0, 8'h20, 1'b0, 32'h66666666, "R7");
        push(CMD_OWN, 0, 8'h30, 1'b0, init_word(8'h30), "R7");
        op(0, 1'b1, 8'h30, 32'h77777777, "R7");
        op(0, 1'b0, 8'h30, 32'h77777777, "R3");
        push(CMD_READ, 1, 8'h20, 1'b0, 32'h66666666, "R8");
        op(1, 1'b0, 8'h20, 32'h66666666, "R7");

        // R11: three concurrent misses share the bus
        free_addr[0] = 8'h05; free_addr[1] = 8'h06; free_addr[2] = 8'h07;
        free_mode = 1'b1;
        fork
            op(0, 1'b0, 8'h05, init_word(8'h05), "R11");
            op(1, 1'b0, 8'h06, init_word(8'h06), "R11");
            op(2, 1'b0, 8'h07, init_word(8'h07), "R11");
        join
        free_mode = 1'b0;
        chk(free_seen == 3, "R11", "concurrent transaction count", DW'(free_seen), 32'd3);

        repeat (3) @(negedge clk);
        done = 1'b1;
        summary();
    end

endmodule